// File: doc/BRIEF.md
# SECDED 64/72 Error-Correcting Codec

This block protects a memory data path with a single-error-correct, double-error-detect code. On the write side it takes data made of one or more 64-bit lanes and produces a 72-bit coded word per lane, ready to be stored. On the read side it takes the stored 72-bit lanes, corrects any single flipped bit, and returns the 64-bit data with one flag for a corrected error and one for an uncorrectable error. Each side is a single register stage with its own enable, so the codec sits directly beside a synchronous memory.

The code is an extended Hamming code: seven Hamming check bits plus one overall parity bit per lane. A build-time mode chooses whether both sides, only the write-side encoder, or only the read-side decoder are active. The write side has two injection inputs that deliberately corrupt the outgoing coded word, so that the correction and detection paths further down the line can be exercised in the system.

Top module: `secded_codec`

## Requirements
- R1: When wr_en is high at a rising clock edge, wr_code shows the coded form of wr_data after that edge; when wr_en is low, wr_code keeps its value.
- R2: Lane l of wr_data (bits 64l to 64l+63) maps to lane l of wr_code (bits 72l to 72l+71). Inside a lane, coded bit 0 is the overall parity bit, bits 1, 2, 4, 8, 16, 32 and 64 are the Hamming check bits, and the 64 data bits fill the remaining positions 3, 5, 6, 7, 9 and upward in ascending order. Data value 1 codes to 72'h00F, data bit 63 alone codes to 72'h81_0000_0000_0000_0017, and zero codes to zero.
- R3: Without injection, every coded lane has even parity over all 72 bits.
- R4: With inj_single high and inj_double low, every coded lane has coded bit 3 (data bit 0) inverted after encoding.
- R5: With inj_double high, every coded lane has coded bits 3 and 5 (data bits 0 and 1) inverted, whatever the value of inj_single.
- R6: An error-free coded word read with rd_en high returns its data on rd_data one cycle later with both flags low.
- R7: A word with any one of its 72 bits flipped returns the original data with rd_single_err high and rd_double_err low.
- R8: A flip of only the overall parity bit (coded bit 0) is reported as a single-bit error and the data is returned unchanged.
- R9: A word with two bits flipped raises rd_double_err and leaves rd_single_err low.
- R10: Across lanes, rd_double_err is high when any lane has an uncorrectable error; rd_single_err is high only when some lane was corrected and no lane is uncorrectable. The two flags are never high together.
- R11: When rd_en is low, rd_data and both flags keep their values.
- R12: A synchronous reset clears wr_code, rd_data and both flags to zero; no other reset value exists.
- R13: In encode-only mode the read outputs stay zero; in decode-only mode wr_code stays zero, injection inputs included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Capture enable for the write stage |
| wr_data | input | 64*LANES | Data to encode |
| inj_single | input | 1 | Corrupt one data bit of each coded lane |
| inj_double | input | 1 | Corrupt two data bits of each coded lane, wins over inj_single |
| wr_code | output | 72*LANES | Registered coded word |
| rd_en | input | 1 | Capture enable for the read stage |
| rd_code | input | 72*LANES | Stored coded word to check |
| rd_data | output | 64*LANES | Registered corrected data |
| rd_single_err | output | 1 | A single-bit error was corrected in the word on rd_data |
| rd_double_err | output | 1 | An uncorrectable error is present in the word on rd_data |

## Verification
A wrong check-bit equation in the encoder appears on wr_code one cycle after the write and breaks either the fixed vectors or the even parity of the lane; a wrong syndrome decode appears one cycle after a read as a miscorrected bit on rd_data or a wrong flag. The bench sweeps a flip through every position of each lane and flips neighbouring pairs, so a single wrong position in the bit map or a wrong priority between the parity and syndrome cases shows at the ports on the very next cycle. Hold behaviour with enables low and the mode gating are checked by holding the inputs busy while watching the outputs stay put.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DW   = 64;   // data bits per lane
  localparam int CW   = 72;   // coded bits per lane
  localparam int NCHK = 7;    // Hamming check bits per lane

  // coded positions of data bits 0 and 1, used by error injection
  localparam int POS_INJ0 = 3;
  localparam int POS_INJ1 = 5;

  typedef enum logic [1:0] {
    MODE_BOTH     = 2'd0,
    MODE_ENC_ONLY = 2'd1,
    MODE_DEC_ONLY = 2'd2
  } codec_mode_e;

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Build a coded lane: scatter the data, then fill check and parity bits.
  function automatic logic [CW-1:0] secded_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < NCHK; k++) begin
      for (int p = 1; p < CW; p++) begin
        if (!is_pow2(p) && p[k]) c[1 << k] = c[1 << k] ^ c[p];
      end
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  // Gather the data bits back out of a coded lane.
  function automatic logic [DW-1:0] secded_extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        d[j] = c[p];
        j++;
      end
    end
    return d;
  endfunction

  // Hamming syndrome over positions 1..71 (check bits included).
  function automatic logic [NCHK-1:0] secded_syndrome(input logic [CW-1:0] c);
    logic [NCHK-1:0] s;
    s = '0;
    for (int k = 0; k < NCHK; k++) begin
      for (int p = 1; p < CW; p++) begin
        if (p[k]) s[k] = s[k] ^ c[p];
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/secded_enc_lane.sv
module secded_enc_lane
  import secded_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic          inj_single_i,
  input  logic          inj_double_i,
  output logic [CW-1:0] code_o
);

  logic [CW-1:0] clean;

  always_comb begin
    clean  = secded_encode(data_i);
    code_o = clean;
    if (inj_double_i) begin
      code_o[POS_INJ0] = ~clean[POS_INJ0];
      code_o[POS_INJ1] = ~clean[POS_INJ1];
    end else if (inj_single_i) begin
      code_o[POS_INJ0] = ~clean[POS_INJ0];
    end
  end

endmodule

// File: rtl/secded_dec_lane.sv
module secded_dec_lane
  import secded_pkg::*;
(
  input  logic [CW-1:0] code_i,
  output logic [DW-1:0] data_o,
  output logic          fixed_o,
  output logic          uncorr_o
);

  logic [NCHK-1:0] syn;
  logic            par_bad;
  logic [CW-1:0]   repaired;

  always_comb begin
    syn      = secded_syndrome(code_i);
    par_bad  = ^code_i;
    repaired = code_i;
    fixed_o  = 1'b0;
    uncorr_o = 1'b0;
    if (par_bad) begin
      if (syn == '0) begin
        // only the overall parity bit is wrong
        repaired[0] = ~code_i[0];
        fixed_o     = 1'b1;
      end else if (syn < NCHK'(CW)) begin
        repaired[syn] = ~code_i[syn];
        fixed_o       = 1'b1;
      end else begin
        // odd weight pointing outside the lane: more than one bit
        uncorr_o = 1'b1;
      end
    end else if (syn != '0) begin
      uncorr_o = 1'b1;
    end
    data_o = secded_extract(repaired);
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter int          LANES = 2,
  parameter codec_mode_e MODE  = MODE_BOTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [LANES*64-1:0]   wr_data,
  input  logic                  inj_single,
  input  logic                  inj_double,
  output logic [LANES*72-1:0]   wr_code,
  input  logic                  rd_en,
  input  logic [LANES*72-1:0]   rd_code,
  output logic [LANES*64-1:0]   rd_data,
  output logic                  rd_single_err,
  output logic                  rd_double_err
);

  localparam int  DATA_W  = LANES * DW;
  localparam int  CODE_W  = LANES * CW;
  localparam bit  HAS_ENC = (MODE != MODE_DEC_ONLY);
  localparam bit  HAS_DEC = (MODE != MODE_ENC_ONLY);

  logic [CODE_W-1:0] enc_code;
  logic [DATA_W-1:0] dec_data;
  logic [LANES-1:0]  lane_fixed;
  logic [LANES-1:0]  lane_uncorr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    secded_enc_lane u_enc (
      .data_i       (wr_data[l*DW +: DW]),
      .inj_single_i (inj_single),
      .inj_double_i (inj_double),
      .code_o       (enc_code[l*CW +: CW])
    );
    secded_dec_lane u_dec (
      .code_i   (rd_code[l*CW +: CW]),
      .data_o   (dec_data[l*DW +: DW]),
      .fixed_o  (lane_fixed[l]),
      .uncorr_o (lane_uncorr[l])
    );
  end

  logic any_uncorr;
  logic any_fixed;
  assign any_uncorr = |lane_uncorr;
  assign any_fixed  = |lane_fixed;

  // write stage
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_code <= '0;
    end else if (wr_en && HAS_ENC) begin
      wr_code <= enc_code;
    end
  end

  // read stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data       <= '0;
      rd_single_err <= 1'b0;
      rd_double_err <= 1'b0;
    end else if (rd_en && HAS_DEC) begin
      rd_data       <= dec_data;
      rd_single_err <= any_fixed && !any_uncorr;
      rd_double_err <= any_uncorr;
    end
  end

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
  import secded_pkg::*;
#(
  parameter int          LANES = 2,
  parameter codec_mode_e MODE  = MODE_BOTH
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                inj_single,
  input logic                inj_double,
  input logic [LANES*72-1:0] wr_code,
  input logic                rd_en,
  input logic [LANES*64-1:0] rd_data,
  input logic                rd_single_err,
  input logic                rd_double_err
);

  p_wr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_code));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(rd_data) && $stable(rd_single_err) && $stable(rd_double_err)));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rd_single_err && rd_double_err));

  p_reset_zero_r12: assert property (@(posedge clk)
    rst |=> (wr_code == '0 && rd_data == '0 && !rd_single_err && !rd_double_err));

  if (MODE != MODE_DEC_ONLY) begin : g_enc
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      p_even_parity_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !inj_single && !inj_double) |=> (^wr_code[l*72 +: 72]) == 1'b0);
      p_single_inj_odd_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && inj_single && !inj_double) |=> (^wr_code[l*72 +: 72]) == 1'b1);
      p_double_inj_even_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && inj_double) |=> (^wr_code[l*72 +: 72]) == 1'b0);
    end
  end

  if (MODE == MODE_ENC_ONLY) begin : g_no_dec
    p_read_idle_r13: assert property (@(posedge clk) disable iff (rst)
      (rd_data == '0 && !rd_single_err && !rd_double_err));
  end

  if (MODE == MODE_DEC_ONLY) begin : g_no_enc
    p_write_idle_r13: assert property (@(posedge clk) disable iff (rst)
      wr_code == '0);
  end

endmodule

bind secded_codec secded_codec_chk #(.LANES(LANES), .MODE(MODE)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .inj_single    (inj_single),
  .inj_double    (inj_double),
  .wr_code       (wr_code),
  .rd_en         (rd_en),
  .rd_data       (rd_data),
  .rd_single_err (rd_single_err),
  .rd_double_err (rd_double_err)
);

// File: tb/test_secded_codec.sv
`timescale 1ns/1ps
module test_secded_codec;
  import secded_pkg::*;

  localparam int LANES = 2;
  localparam int DWT = LANES * 64;
  localparam int CWT = LANES * 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, inj_single = 1'b0, inj_double = 1'b0, rd_en = 1'b0;
  logic [DWT-1:0] wr_data = '0;
  logic [CWT-1:0] rd_code = '0;

  logic [CWT-1:0] wc_both, wc_enc, wc_dec;
  logic [DWT-1:0] rd_both, rd_enc, rd_dec;
  logic sb_both, db_both, sb_enc, db_enc, sb_dec, db_dec;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  secded_codec #(.LANES(LANES), .MODE(MODE_BOTH)) i_secded_codec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .inj_single(inj_single), .inj_double(inj_double), .wr_code(wc_both),
    .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_both),
    .rd_single_err(sb_both), .rd_double_err(db_both));

  secded_codec #(.LANES(LANES), .MODE(MODE_ENC_ONLY)) i_secded_codec_enc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .inj_single(inj_single), .inj_double(inj_double), .wr_code(wc_enc),
    .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_enc),
    .rd_single_err(sb_enc), .rd_double_err(db_enc));

  secded_codec #(.LANES(LANES), .MODE(MODE_DEC_ONLY)) i_secded_codec_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .inj_single(inj_single), .inj_double(inj_double), .wr_code(wc_dec),
    .rd_en(rd_en), .rd_code(rd_code), .rd_data(rd_dec),
    .rd_single_err(sb_dec), .rd_double_err(db_dec));

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write_word(input logic [DWT-1:0] d, input bit s, input bit dd,
                            output logic [CWT-1:0] code);
    wr_data = d; inj_single = s; inj_double = dd; wr_en = 1'b1;
    step();
    code = wc_both;
    wr_en = 1'b0; inj_single = 1'b0; inj_double = 1'b0;
  endtask

  task automatic read_word(input logic [CWT-1:0] c);
    rd_code = c; rd_en = 1'b1;
    step();
    rd_en = 1'b0;
  endtask

  localparam logic [DWT-1:0] PAT_A = {64'hDEAD_BEEF_0123_4567, 64'hA5A5_0F0F_3C3C_9696};

  task automatic t_reset();
    check("R12 reset both", {wc_both, rd_both, sb_both, db_both}, '0);
    check("R12 reset enc", {wc_enc, rd_enc, sb_enc, db_enc}, '0);
    check("R12 reset dec", {wc_dec, rd_dec, sb_dec, db_dec}, '0);
  endtask

  task automatic t_known_vectors();
    logic [CWT-1:0] c;
    write_word({64'h8000_0000_0000_0000, 64'h1}, 1'b0, 1'b0, c);
    check("R2 lane0 data 1", c[71:0], 72'h00F);
    check("R2 lane1 data bit63", c[143:72], 72'h81_0000_0000_0000_0017);
    check("R1 enc-only same code", wc_enc, c);
    write_word({64'h0, 64'h2}, 1'b0, 1'b0, c);
    check("R2 lane0 data 2", c[71:0], 72'h033);
    check("R2 lane1 zero", c[143:72], 72'h0);
  endtask

  task automatic t_hold();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b0, 1'b0, c);
    read_word(c);
    wr_data = ~PAT_A; inj_single = 1'b1;
    rd_code = ~c;
    step();
    inj_single = 1'b0;
    check("R1 write stage holds", wc_both, c);
    check("R11 read stage holds", {rd_both, sb_both, db_both}, {PAT_A, 2'b00});
  endtask

  task automatic t_clean();
    logic [CWT-1:0] c;
    logic [DWT-1:0] pats [5];
    pats[0] = '0; pats[1] = '1; pats[2] = PAT_A;
    pats[3] = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    pats[4] = {64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA};
    for (int i = 0; i < 5; i++) begin
      write_word(pats[i], 1'b0, 1'b0, c);
      check("R3 lane0 even parity", ^c[71:0], 1'b0);
      check("R3 lane1 even parity", ^c[143:72], 1'b0);
      read_word(c);
      check("R6 clean round trip", {rd_both, sb_both, db_both}, {pats[i], 2'b00});
    end
  endtask

  task automatic t_single_sweep();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b0, 1'b0, c);
    for (int b = 0; b < CWT; b++) begin
      read_word(c ^ (CWT'(1) << b));
      if (b == 0 || b == 72)
        check("R8 parity bit flip", {rd_both, sb_both, db_both}, {PAT_A, 2'b10});
      else
        check("R7 single flip corrected", {rd_both, sb_both, db_both}, {PAT_A, 2'b10});
    end
  endtask

  task automatic t_double();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b0, 1'b0, c);
    for (int b = 0; b < 71; b++) begin
      read_word(c ^ (CWT'(3) << b));
      check("R9 adjacent double flip", {sb_both, db_both}, 2'b01);
    end
    read_word(c ^ (CWT'(1) << 0) ^ (CWT'(1) << 71));
    check("R9 parity plus top bit", {sb_both, db_both}, 2'b01);
    read_word(c ^ (CWT'(1) << 80) ^ (CWT'(1) << 130));
    check("R9 double in lane1", {sb_both, db_both}, 2'b01);
  endtask

  task automatic t_inject();
    logic [CWT-1:0] c;
    write_word('0, 1'b1, 1'b0, c);
    check("R4 single injection", c, {72'h008, 72'h008});
    read_word(c);
    check("R4 single injection corrected", {rd_both, sb_both, db_both}, {{DWT{1'b0}}, 2'b10});
    write_word('0, 1'b0, 1'b1, c);
    check("R5 double injection", c, {72'h028, 72'h028});
    read_word(c);
    check("R5 double injection detected", {sb_both, db_both}, 2'b01);
    write_word('0, 1'b1, 1'b1, c);
    check("R5 double wins over single", c, {72'h028, 72'h028});
    write_word({64'h0, 64'h1}, 1'b1, 1'b0, c);
    check("R4 injection on data 1", c[71:0], 72'h007);
  endtask

  task automatic t_lanes();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b0, 1'b0, c);
    read_word(c ^ (CWT'(1) << 10) ^ (CWT'(3) << 100));
    check("R10 single plus double lanes", {sb_both, db_both}, 2'b01);
    read_word(c ^ (CWT'(1) << 10) ^ (CWT'(1) << 100));
    check("R10 single in each lane", {rd_both, sb_both, db_both}, {PAT_A, 2'b10});
  endtask

  task automatic t_modes();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b1, 1'b1, c);
    check("R13 decode-only write idle", wc_dec, '0);
    write_word(PAT_A, 1'b0, 1'b0, c);
    read_word(c ^ (CWT'(1) << 40));
    check("R13 encode-only read idle", {rd_enc, sb_enc, db_enc}, '0);
    check("R13 decode-only corrects", {rd_dec, sb_dec, db_dec}, {PAT_A, 2'b10});
    check("R13 decode-only write still idle", wc_dec, '0);
  endtask

  task automatic t_midreset();
    logic [CWT-1:0] c;
    write_word(PAT_A, 1'b0, 1'b0, c);
    read_word(c ^ (CWT'(1) << 5));
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R12 reset clears state", {wc_both, rd_both, sb_both, db_both}, '0);
  endtask

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_known_vectors();
    t_hold();
    t_clean();
    t_single_sweep();
    t_double();
    t_inject();
    t_lanes();
    t_modes();
    t_midreset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule